// File: doc/BRIEF.md
# Quad DAC serial load interface

This block is the digital front end of a four-channel 8-bit converter. It samples a serial clock, a serial data line and a load strobe with the system clock. It collects a 10-bit frame on the serial link and, when the load strobe goes low, moves the 8-bit code into one of four channel code registers. Downstream converter logic reads the four codes in parallel. It also receives a one-cycle update pulse for whichever channel was just written. Each code N stands for an output of N/256 of full scale, so 0 gives zero output and 255 gives full scale less one LSB.

The serial inputs are brought into the system clock domain through two-stage synchronizers, and edges are detected there. A separate mode input selects 3-wire operation. When it is low, the 2-wire protocol is assumed, and this block only reports that mode: it neither shifts nor loads.

Top module: `qdac_serial_front`

## Requirements
- R1: While `rst` is high at a clock edge, all four channel codes become 0, the shift register is cleared and no update pulse is asserted.
- R2: A frame is 10 bits sent MSB first: the 2 address bits come first, then 8 code bits. Address 0..3 selects channel 0..3, and channel i is presented on `code_o[8*i +: 8]`.
- R3: Bits are captured only on a falling edge of `ser_clk_i`. Changes on `ser_dat_i` while `ser_clk_i` is steady shift nothing.
- R4: In 3-wire mode, a falling edge of `ser_ld_i` writes the code of the last frame into the addressed channel, and leaves the other three channels unchanged.
- R5: Each load asserts exactly the addressed bit of `upd_o` for exactly one system clock. The new code is visible on `code_o` within 4 clocks of the load strobe going low.
- R6: When more than 10 bits arrive before a load, only the most recent 10 bits form the frame.
- R7: When `mode_sel_i` is low (2-wire), `mode3w_o` is 0, serial bits are not shifted, and load strobes change no channel and raise no update pulse. When it is high, `mode3w_o` is 1.
- R8: A load does not clear the shift register, so a second load with no new bits rewrites the same channel with the same code and pulses it again.
- R9: The extreme codes 0 and 255 are stored and presented unchanged. A code holds until its channel is loaded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk_i | input | 1 | Serial clock, idles high, data taken on its falling edge |
| ser_dat_i | input | 1 | Serial data |
| ser_ld_i | input | 1 | Load strobe, idles high, active on its falling edge |
| mode_sel_i | input | 1 | 1 selects 3-wire operation, 0 the 2-wire mode |
| mode3w_o | output | 1 | Synchronized mode indication, 1 when 3-wire is active |
| code_o | output | 32 | Four 8-bit channel codes, channel i at bits 8*i+7..8*i |
| upd_o | output | 4 | One-cycle update pulse per channel |

## Verification
The assertions assume that serial data and the load strobe are held steady around every serial clock edge. They also assume that each level on the serial pins lasts longer than the two synchronizer stages, so that every edge is seen exactly once. They further assume that the mode input is quasi-static while a load is in flight. The stimulus holds every serial level for four system clocks and moves data only while the serial clock is high. It changes the mode only while the link is idle, then waits several clocks before the next frame, so the bench stays inside these assumptions.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int CODE_W = 8;
  localparam int ADDR_W = 2;
  localparam int NUM_CH = 1 << ADDR_W;
  localparam int FRAME_W = ADDR_W + CODE_W;

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [CODE_W-1:0]  code_t;
  typedef logic [ADDR_W-1:0]  chan_t;

  // address field sits in the top bits because it is shifted in first
  function automatic chan_t frame_chan(input frame_t f);
    return f[FRAME_W-1 -: ADDR_W];
  endfunction

  function automatic code_t frame_code(input frame_t f);
    return f[CODE_W-1:0];
  endfunction

  function automatic frame_t frame_push(input frame_t f, input logic b);
    return {f[FRAME_W-2:0], b};
  endfunction
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= RST_VAL;
    else     stage_q[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stage_q[k] <= RST_VAL;
      else     stage_q[k] <= stage_q[k-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter
  import qdac_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   shift_en,
  input  logic   bit_in,
  output frame_t frame_o
);
  frame_t sr_q;

  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (shift_en) sr_q <= frame_push(sr_q, bit_in);
  end

  assign frame_o = sr_q;

  // R3: without a detected serial clock fall the frame must not move
  assert_frame_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(sr_q));
endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank
  import qdac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  chan_t                    wr_chan,
  input  code_t                    wr_code,
  output logic [NUM_CH*CODE_W-1:0] codes_o,
  output logic [NUM_CH-1:0]        upd_o
);
  code_t             code_q [NUM_CH];
  logic [NUM_CH-1:0] upd_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit_w;
    assign hit_w = wr_en && (wr_chan == chan_t'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        code_q[i] <= '0;
        upd_q[i]  <= 1'b0;
      end else begin
        upd_q[i] <= hit_w;
        if (hit_w) code_q[i] <= wr_code;
      end
    end

    assign codes_o[i*CODE_W +: CODE_W] = code_q[i];

    // R9: a channel keeps its code unless its own update fired
    assert_code_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !upd_q[i] |-> $stable(code_q[i]));
  end

  assign upd_o = upd_q;

  // R5: never more than one channel updated in a cycle
  assert_single_update_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(upd_q));
endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front
  import qdac_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ser_clk_i,
  input  logic                     ser_dat_i,
  input  logic                     ser_ld_i,
  input  logic                     mode_sel_i,
  output logic                     mode3w_o,
  output logic [NUM_CH*CODE_W-1:0] code_o,
  output logic [NUM_CH-1:0]        upd_o
);
  localparam int NSIG = 4;

  logic [NSIG-1:0] raw_w, syn_w;
  logic            sclk_s, sdat_s, sld_s, mode_s;
  logic            sclk_prev_q, sld_prev_q;
  logic            sclk_fall_w, ld_fall_w, shift_en_w, load_strobe_w;
  frame_t          frame_w;

  assign raw_w = {mode_sel_i, ser_ld_i, ser_dat_i, ser_clk_i};

  // serial clock and load idle high: reset them high to avoid a false edge
  qdac_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(4'b0101)) u_sync (
    .clk(clk), .rst(rst), .d(raw_w), .q(syn_w)
  );

  assign {mode_s, sld_s, sdat_s, sclk_s} = syn_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q <= 1'b1;
      sld_prev_q  <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s;
      sld_prev_q  <= sld_s;
    end
  end

  assign sclk_fall_w   = sclk_prev_q && !sclk_s;
  assign ld_fall_w     = sld_prev_q && !sld_s;
  assign shift_en_w    = sclk_fall_w && mode_s;
  assign load_strobe_w = ld_fall_w && mode_s;
  assign mode3w_o      = mode_s;

  qdac_shifter u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en_w), .bit_in(sdat_s), .frame_o(frame_w)
  );

  qdac_chan_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(load_strobe_w),
    .wr_chan(frame_chan(frame_w)), .wr_code(frame_code(frame_w)),
    .codes_o(code_o), .upd_o(upd_o)
  );

  // R4: any update must follow a load strobe edge seen one cycle earlier
  assert_upd_after_load_R4: assert property (@(posedge clk) disable iff (rst)
    (|upd_o) |-> $past(ld_fall_w));

  // R7: no update can come from a cycle spent in 2-wire mode
  assert_no_upd_2wire_R7: assert property (@(posedge clk) disable iff (rst)
    (|upd_o) |-> $past(mode_s));

  // R5: an update pulse never lasts two cycles on the same channel
  assert_pulse_short_R5: assert property (@(posedge clk) disable iff (rst)
    (|upd_o) |=> ((upd_o & $past(upd_o)) == '0));
endmodule

// File: tb/qdac_serial_front_tb.sv
module qdac_serial_front_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b1, ser_dat = 1'b0, ser_ld = 1'b1, mode_sel = 1'b1;
  logic        mode3w;
  logic [31:0] code;
  logic [3:0]  upd;

  int total = 0;
  int bad = 0;
  int upd_cnt [4];
  logic [7:0] exp_code [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  qdac_serial_front u_dut (
    .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_ld_i(ser_ld), .mode_sel_i(mode_sel), .mode3w_o(mode3w),
    .code_o(code), .upd_o(upd)
  );

  // count high cycles of each update line, sampled away from the edge
  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) if (upd[i]) upd_cnt[i]++;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int i = 0; i < 4; i++) upd_cnt[i] = 0;
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    wait_clk(HOLD);
    ser_clk = 1'b0;
    wait_clk(HOLD);
    ser_clk = 1'b1;
    wait_clk(HOLD);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    for (int k = n - 1; k >= 0; k--) send_bit(v[k]);
  endtask

  task automatic do_load();
    ser_ld = 1'b0;
    wait_clk(HOLD);
    ser_ld = 1'b1;
    wait_clk(HOLD);
  endtask

  function automatic logic [31:0] pack_exp();
    return {exp_code[3], exp_code[2], exp_code[1], exp_code[0]};
  endfunction

  task automatic check_counts(input string req, input int ch);
    for (int i = 0; i < 4; i++)
      check(req, upd_cnt[i], (i == ch) ? 1 : 0);
  endtask

  task automatic load_frame(input string req, input logic [1:0] a, input logic [7:0] c);
    clear_counts();
    send_bits({6'b0, a, c}, 10);
    ser_ld = 1'b0;
    wait_clk(4);                 // R5: code must be visible within 4 clocks
    exp_code[a] = c;
    check(req, code, pack_exp());
    ser_ld = 1'b1;
    wait_clk(HOLD);
    check_counts(req, a);
  endtask

  task automatic t_reset();
    check("R1 code", code, 32'h0);
    check("R1 upd", {28'h0, upd}, 32'h0);
    check("R7 mode", {31'h0, mode3w}, 32'h1);
  endtask

  task automatic t_all_channels();
    load_frame("R2 chA", 2'd0, 8'hA5);
    load_frame("R2 chB", 2'd1, 8'h3C);
    load_frame("R4 chC", 2'd2, 8'h81);
    load_frame("R4 chD", 2'd3, 8'h5E);
  endtask

  task automatic t_extremes();
    load_frame("R9 max", 2'd1, 8'hFF);
    load_frame("R9 zero", 2'd2, 8'h00);
    wait_clk(20);
    check("R9 hold", code, pack_exp());
  endtask

  task automatic t_overlong();
    clear_counts();
    send_bits(16'b111101_00_11110000, 16);   // R6: only last 10 kept -> ch0 F0
    do_load();
    exp_code[0] = 8'hF0;
    check("R6 last10", code, pack_exp());
    check_counts("R6 upd", 0);
  endtask

  task automatic t_data_no_clock();
    send_bits({6'b0, 2'd3, 8'h6B}, 10);
    for (int k = 0; k < 6; k++) begin
      ser_dat = k[0];
      wait_clk(HOLD);
    end
    clear_counts();
    do_load();
    exp_code[3] = 8'h6B;
    check("R3 noshift", code, pack_exp());
    check_counts("R3 upd", 3);
  endtask

  task automatic t_reload();
    clear_counts();
    do_load();
    check("R8 reload", code, pack_exp());
    check_counts("R8 upd", 3);
  endtask

  task automatic t_two_wire();
    mode_sel = 1'b0;
    wait_clk(6);
    check("R7 mode0", {31'h0, mode3w}, 32'h0);
    clear_counts();
    send_bits({6'b0, 2'd0, 8'h11}, 10);
    do_load();
    check("R7 nowrite", code, pack_exp());
    check_counts("R7 noupd", -1);
    mode_sel = 1'b1;
    wait_clk(6);
    check("R7 mode1", {31'h0, mode3w}, 32'h1);
    clear_counts();
    do_load();                    // shifter untouched: still ch3 6B
    check("R7 noshift", code, pack_exp());
    check_counts("R7 reupd", 3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      exp_code[i] = 8'h00;
      upd_cnt[i] = 0;
    end
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_all_channels();
    t_extremes();
    t_overlong();
    t_data_no_clock();
    t_reload();
    t_two_wire();
    rst = 1'b1;
    wait_clk(2);
    check("R1 rerst", code, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule